// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Daisy-Chain Link

This block arbitrates the interrupt requests of one channel of a serial communications peripheral. Six request groups feed it, each as a single summary request line. For each group the block keeps a pending flag, an enable flag and an in-service flag. A channel-wide master enable gates all requests. The groups are ranked in a fixed order. The channel also sits in an external priority chain: it receives an enable-in from the device above it and passes an enable-out to the device below it.

When the highest-ranked unblocked group has a pending, enabled request and enable-in is high, the block raises its interrupt request. On the CPU's acknowledge pulse it marks that group as in service and returns a vector one cycle later. The vector is a base value with the group's code spliced in, or the unchanged base, or nothing. Software writes a command to end service of the highest-ranked group in service. It clears pending flags by writing ones, and it can poll the pending flags with interrupts off.

Top module: `irq_chain_ctrl`

## Requirements
- R1: While reset is low, all pending, enable and in-service flags are 0, int_req and vec_valid are 0, and ieo follows iei.
- R2: A pending flag is set in the cycle after its src_req bit is high. It stays set until a 1 is written to its ip_clr bit. When set and clear fall in the same cycle, set wins.
- R3: A group is active only when its pending, its enable (loaded from ie_wdata on ie_wr) and mie are all 1. int_req can be 1 only while iei is 1.
- R4: The groups rank from index 0 (receive status) to index 5 (device status). Group i wins when it is active, no lower-index group is active, and no group of index i or lower is in service. int_req equals iei AND a winner exists.
- R5: ieo equals iei AND no group active AND no group in service.
- R6: An acknowledge pulse on inta sets the in-service flag of the winner, but only while int_req is 1. vec_valid is 1 in the next cycle and only then. An acknowledge while int_req is 0 changes no state.
- R7: With vmod=1, vec_out equals ivr_base with bits [3:1] replaced by the winner's index (0..5). With vmod=0, vec_out equals ivr_base.
- R8: With no_vec=1 at the acknowledge, the in-service flag is still set but vec_valid stays 0.
- R9: A pulse on rst_ius clears only the lowest-index in-service flag. An acknowledge in the same cycle still sets the winner's flag.
- R10: ip_status shows the pending flags whatever the enable and mie values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 6 | Summary request of each group, index 0 highest |
| ip_clr | input | 6 | Write-one-to-clear strobes for the pending flags |
| ie_wr | input | 1 | Load strobe for the enable flags |
| ie_wdata | input | 6 | New enable flags |
| mie | input | 1 | Master enable for the channel |
| iei | input | 1 | Chain enable-in from the higher-priority device |
| inta | input | 1 | Interrupt acknowledge pulse |
| rst_ius | input | 1 | Command: end service of the highest-ranked group in service |
| vmod | input | 1 | 1: splice group code into vector bits [3:1] |
| no_vec | input | 1 | 1: return no vector on acknowledge |
| ivr_base | input | 8 | Base interrupt vector |
| int_req | output | 1 | Interrupt request to the CPU |
| ieo | output | 1 | Chain enable-out to the lower-priority device |
| vec_valid | output | 1 | Vector on vec_out is driven this cycle |
| vec_out | output | 8 | Acknowledge vector |
| ip_status | output | 6 | Pending flags, for polling |
| ius_status | output | 6 | In-service flags |

## Verification
Two pairs of functions can act in the same cycle. An acknowledge can meet an end-of-service command, and a new source request can meet a write-one-to-clear of the same pending flag. A long random sweep provokes both pairs. It drives sparse, overlapping pulses on inta, rst_ius, src_req and ip_clr, along with random enables, master enable, chain input and vector mode. A cycle-accurate bench model judges each cycle. It expects the acknowledged flag to be set while the old lowest in-service flag clears, and it expects the set to win over the clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int GRP_N  = 6;
  localparam int CODE_W = 3;
  typedef logic [GRP_N-1:0]  grp_vec_t;
  typedef logic [CODE_W-1:0] code_t;

  // isolate the lowest-index set bit (highest priority)
  function automatic grp_vec_t lowest_set(input grp_vec_t v);
    return v & (~v + grp_vec_t'(1));
  endfunction

  // encode a one-hot group vector into its index
  function automatic code_t onehot_to_code(input grp_vec_t oh);
    code_t c;
    c = '0;
    for (int i = 0; i < GRP_N; i++)
      if (oh[i]) c = c | code_t'(i);
    return c;
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  grp_vec_t src_req,
  input  grp_vec_t ip_clr,
  input  logic     ie_wr,
  input  grp_vec_t ie_wdata,
  output grp_vec_t pend,
  output grp_vec_t ie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ie   <= '0;
    end else begin
      pend <= (pend & ~ip_clr) | src_req;
      if (ie_wr) ie <= ie_wdata;
    end
  end
endmodule

// File: rtl/irq_prio_chain.sv
module irq_prio_chain
  import irq_pkg::*;
(
  input  grp_vec_t active,
  input  grp_vec_t ius,
  input  logic     iei,
  output grp_vec_t win_oh,
  output logic     any_win,
  output logic     ieo
);
  grp_vec_t ius_pre;  // OR of ius[i:0]
  grp_vec_t act_pre;  // OR of active[i-1:0]

  for (genvar i = 0; i < GRP_N; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign ius_pre[i] = ius[i];
      assign act_pre[i] = 1'b0;
    end else begin : g_link
      assign ius_pre[i] = ius_pre[i-1] | ius[i];
      assign act_pre[i] = act_pre[i-1] | active[i-1];
    end
    assign win_oh[i] = active[i] & ~ius_pre[i] & ~act_pre[i];
  end

  assign any_win = |win_oh;
  assign ieo     = iei & ~(|active) & ~(|ius);
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int CODE_LSB = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_take,
  input  grp_vec_t         win_oh,
  input  logic             rst_ius,
  input  logic             vmod,
  input  logic             no_vec,
  input  logic [VEC_W-1:0] ivr_base,
  output grp_vec_t         ius,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);
  function automatic logic [VEC_W-1:0] splice(input logic [VEC_W-1:0] b, input code_t c);
    logic [VEC_W-1:0] v;
    v = b;
    v[CODE_LSB +: CODE_W] = c;
    return v;
  endfunction

  grp_vec_t ius_clr, ius_set;
  assign ius_clr = rst_ius  ? lowest_set(ius) : '0;
  assign ius_set = ack_take ? win_oh          : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ius       <= '0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      ius       <= (ius & ~ius_clr) | ius_set;
      vec_valid <= ack_take & ~no_vec;
      if (ack_take)
        vec_out <= vmod ? splice(ivr_base, onehot_to_code(win_oh)) : ivr_base;
    end
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int CODE_LSB = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       src_req,
  input  logic [5:0]       ip_clr,
  input  logic             ie_wr,
  input  logic [5:0]       ie_wdata,
  input  logic             mie,
  input  logic             iei,
  input  logic             inta,
  input  logic             rst_ius,
  input  logic             vmod,
  input  logic             no_vec,
  input  logic [VEC_W-1:0] ivr_base,
  output logic             int_req,
  output logic             ieo,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out,
  output logic [5:0]       ip_status,
  output logic [5:0]       ius_status
);
  grp_vec_t pend, ie, active, ius, win_oh;
  logic     any_win, ack_take;

  irq_pend_bank i_pend (
    .clk, .rst_n, .src_req, .ip_clr, .ie_wr, .ie_wdata, .pend, .ie
  );

  assign active = pend & ie & {GRP_N{mie}};

  irq_prio_chain i_chain (
    .active, .ius, .iei, .win_oh, .any_win, .ieo
  );

  assign int_req  = iei & any_win;
  assign ack_take = inta & int_req;

  irq_ack_unit #(.VEC_W(VEC_W), .CODE_LSB(CODE_LSB)) i_ack (
    .clk, .rst_n, .ack_take, .win_oh, .rst_ius, .vmod, .no_vec,
    .ivr_base, .ius, .vec_valid, .vec_out
  );

  assign ip_status  = pend;
  assign ius_status = ius;
endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       iei,
  input logic       mie,
  input logic       inta,
  input logic       no_vec,
  input logic       int_req,
  input logic       ieo,
  input logic       vec_valid,
  input logic [5:0] win_oh,
  input logic [5:0] ius_status
);
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (iei && mie)); // R3
  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh)); // R4
  AST_IEO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_status) |-> !ieo); // R5
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta && int_req)); // R6
  AST_IUS_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ius_status & ~$past(ius_status)) != 6'd0) |-> $past(inta && int_req)); // R6
  AST_IUS_ONE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ius_status & ~$past(ius_status)) <= 1); // R9
  AST_NOVEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !$past(no_vec)); // R8
endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.VEC_W(VEC_W)) i_chk (
  .clk, .rst_n, .iei, .mie, .inta, .no_vec, .int_req, .ieo,
  .vec_valid, .win_oh, .ius_status
);

// File: tb/test_irq_chain_ctrl.sv
`timescale 1ns/1ps
module test_irq_chain_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_req, ip_clr, ie_wdata;
  logic       ie_wr, mie, iei, inta, rst_ius, vmod, no_vec;
  logic [7:0] ivr_base;
  logic       int_req, ieo, vec_valid;
  logic [7:0] vec_out;
  logic [5:0] ip_status, ius_status;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_chain_ctrl i_irq_chain_ctrl (
    .clk, .rst_n, .src_req, .ip_clr, .ie_wr, .ie_wdata, .mie, .iei,
    .inta, .rst_ius, .vmod, .no_vec, .ivr_base, .int_req, .ieo,
    .vec_valid, .vec_out, .ip_status, .ius_status
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  logic [5:0] m_pend, m_ie, m_ius, m_act;
  logic       exp_vv, exp_int, exp_ieo, found;
  logic [7:0] exp_vec;
  int         win;

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; src_req = '0; ip_clr = '0; ie_wr = 0; ie_wdata = '0;
    mie = 0; iei = 1; inta = 0; rst_ius = 0; vmod = 0; no_vec = 0; ivr_base = '0;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 int_req", int_req, 0);
    chk("R1 vec_valid", vec_valid, 0);
    chk("R1 ip_status", ip_status, 0);
    chk("R1 ius_status", ius_status, 0);
    chk("R1 ieo", ieo, 1);
    rst_n = 1'b1;
    m_pend = '0; m_ie = '0; m_ius = '0; exp_vv = 0; exp_vec = '0;

    for (int step = 0; step < 4000; step++) begin
      @(negedge clk);
      chk("R6/R8 vec_valid", vec_valid, exp_vv);
      if (exp_vv) chk("R7 vec_out", vec_out, exp_vec);
      chk("R2/R10 ip_status", ip_status, m_pend);
      chk("R9 ius_status", ius_status, m_ius);

      src_req  = 6'($urandom) & 6'($urandom) & 6'($urandom);
      ip_clr   = 6'($urandom) & 6'($urandom);
      ie_wr    = ($urandom % 8) == 0;
      ie_wdata = 6'($urandom) | 6'($urandom);
      mie      = ($urandom % 6) != 0;
      iei      = ($urandom % 5) != 0;
      inta     = ($urandom % 3) == 0;
      rst_ius  = ($urandom % 5) == 0;
      vmod     = 1'($urandom);
      no_vec   = ($urandom % 6) == 0;
      ivr_base = 8'($urandom);
      #1;

      m_act = m_pend & m_ie & {6{mie}};
      found = 0; win = 0;
      for (int i = 0; i < 6; i++) begin
        if (!found && m_act[i]) begin
          found = 1;
          win = i;
        end
      end
      // in-service flag at or above the top active group blocks it
      if (found)
        for (int i = 0; i <= win; i++) if (m_ius[i]) found = 0;
      exp_int = iei & found;
      exp_ieo = iei & (m_act == 0) & (m_ius == 0);
      chk("R3/R4 int_req", int_req, exp_int);
      chk("R5 ieo", ieo, exp_ieo);

      if (rst_ius)
        for (int i = 0; i < 6; i++)
          if (m_ius[i]) begin m_ius[i] = 0; break; end
      exp_vv = inta & exp_int & ~no_vec;
      if (inta && exp_int) begin
        m_ius[win] = 1'b1;
        exp_vec = vmod ? {ivr_base[7:4], 3'(win), ivr_base[0]} : ivr_base;
      end
      m_pend = (m_pend & ~ip_clr) | src_req;
      if (ie_wr) m_ie = ie_wdata;
      @(posedge clk);
    end
    summary();
  end
endmodule